// File: doc/BRIEF.md
# Sized-Port Chip Select Bus Controller

This controller runs external bus cycles on behalf of a 32-bit internal master. For each accepted request it drives one transfer-start strobe for a single clock, then asserts one chip select for the data phase. It ends every beat when the device pulls the active-low acknowledge low. The external port can be 32, 16 or 8 bits wide. An access wider than the port is split into as many beats as needed, and the two low address bits step on each beat. Read beats are packed into a right-aligned result with the first beat in the most significant position. Write data goes out on the upper byte lanes of the bus.

Two timing options shape the chip select. With address setup on, chip select goes high for one clock between beats, and the byte write enables stay high on the first data clock of every beat, so a zero-wait write never asserts them. With read hold on, the address stays on the bus for one more clock after the last read beat. A per-beat bus monitor ends the cycle with an error pulse when no acknowledge arrives in time. The master holds its request until it sees a one-cycle done or error pulse.

Top module: `szport_bus_ctl`

## Requirements
- R1: Out of reset and while idle, chip select, transfer start and all four write enables are high (inactive), and done and error are low.
- R2: An accepted request drives transfer start low for exactly one clock with chip select high, and chip select goes low in the following clock. The supervisor output copies the request's supervisor flag from the start clock until the cycle ends.
- R3: The port code (0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = 32-bit) and the size code (0 = byte, 1 = word, 2 or 3 = longword) set the beat count. A 16-bit port takes 2 beats for a longword and 1 otherwise. An 8-bit port takes 4, 2 and 1 beats for longword, word and byte. A 32-bit port always takes 1 beat. The low two address bits start at the request's value and advance by the port width in bytes after each non-final beat.
- R4: Acknowledge is sampled on every rising edge during a data clock. While it is high the beat is held in wait states with address and chip select unchanged.
- R5: Read data is taken from the port's top lanes (D[31:24] for 8-bit, D[31:16] for 16-bit, D[31:0] for 32-bit). Beats are packed right-aligned, with the first beat most significant.
- R6: For write data, the operand (a byte copied into all four lanes, a word copied into both halves, or a longword as is) is shifted left by the beat index times the port width. Write enable bit 3 is D[31:24] and bit 0 is D[7:0]. The lanes that go low are: 8-bit port, bit 3. 16-bit port, bits 3:2, or for a byte bit 3 at even and bit 2 at odd addresses. 32-bit port, all four for a longword, bits 3:2 or 1:0 for a word at address bit 1 = 0 or 1, and a single bit 3 minus the address for a byte.
- R7: With address setup on, chip select is high for exactly one clock between consecutive beats. With it off, chip select stays low across beats.
- R8: With address setup on, the write enables are high on the first data clock of every beat, so they go low only in wait states.
- R9: With read hold on, a read's final acknowledge is followed by one clock with chip select high and the address unchanged, and done follows that clock.
- R10: With a non-zero timeout T, a beat with no acknowledge on its T data-clock edges ends the cycle. Error pulses in the next clock with chip select high, and done stays low. A timeout of zero disables the monitor.
- R11: Done pulses for one clock, in the clock after the final acknowledge (or after the hold clock). Done and error never coincide, and a request still valid while done is shown is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port | input | 2 | Port width code |
| cfg_aset | input | 1 | Address setup enable |
| cfg_rhold | input | 1 | Read address hold enable |
| cfg_timeout | input | MON_W | Bus monitor limit in data clocks, 0 = off |
| req_valid | input | 1 | Master request, held until done or error |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | Supervisor access flag |
| req_wdata | input | 32 | Write operand, right-aligned |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | One-clock bus error pulse |
| rsp_rdata | output | 32 | Assembled read data |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_super | output | 1 | Supervisor/user indication |
| bus_addr | output | ADDR_W | Bus address with stepped low bits |
| bus_we_n | output | 4 | Byte write enables, active low |
| bus_dout | output | 32 | Write data to the device |
| bus_din | input | 32 | Read data from the device |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |

## Verification
The bound checker watches, on every clock, the strobe and chip select order. It also checks that write enables appear only under chip select, that the address holds through wait states and that the first data clock carries no write enable when address setup is on. Last, it checks that done and error are separate single pulses with the bus released. Beat counts, address stepping, big-endian packing of read data, write lane placement, the gap clock between beats, the hold clock and the exact timeout count depend on the port, size and option mix. Only the bench's scenarios, each run against a modelled device, can show them.

// File: rtl/szbus_pkg.sv
package szbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_GAP   = 3'd3,
      ST_HOLD  = 3'd4
   } state_t;

   // lane bits carried per beat
   function automatic logic [5:0] port_bits(input logic [1:0] port);
      case (port)
         2'd1:    return 6'd16;
         2'd2:    return 6'd8;
         default: return 6'd32;
      endcase
   endfunction

   // low-address step per beat, modulo 4
   function automatic logic [1:0] port_step(input logic [1:0] port);
      case (port)
         2'd1:    return 2'd2;
         2'd2:    return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic [2:0] beat_count(input logic [1:0] port, input logic [1:0] size);
      case (port)
         2'd1:    return size[1] ? 3'd2 : 3'd1;
         2'd2:    return size[1] ? 3'd4 : (size[0] ? 3'd2 : 3'd1);
         default: return 3'd1;
      endcase
   endfunction

   // active-high lane mask, bit 3 = D[31:24]
   function automatic logic [3:0] lane_mask(input logic [1:0] port, input logic [1:0] size,
                                            input logic [1:0] alo);
      case (port)
         2'd2:    return 4'b1000;
         2'd1:    return (size != 2'd0) ? 4'b1100 : (alo[0] ? 4'b0100 : 4'b1000);
         default: begin
            if (size[1])      return 4'b1111;
            else if (size[0]) return alo[1] ? 4'b0011 : 4'b1100;
            else              return 4'b1000 >> alo;
         end
      endcase
   endfunction

endpackage

// File: rtl/szbus_mon.sv
module szbus_mon #(
   parameter int MON_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_data,
   input  logic             ta_n,
   input  logic [MON_W-1:0] limit,
   output logic             expired,
   output logic             first
);
   logic [MON_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!in_data || !ta_n) cnt_q <= '0;
      else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
   end

   assign expired = in_data && ta_n && (limit != '0) && (cnt_q == limit - 1'b1);
   assign first   = (cnt_q == '0);
endmodule

// File: rtl/szbus_fsm.sv
module szbus_fsm
   import szbus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_write,
   input  logic       ta_n,
   input  logic       aset,
   input  logic       rhold,
   input  logic [2:0] nbeats,
   input  logic [1:0] step,
   input  logic [1:0] alo_init,
   input  logic       expired,
   output state_t     st,
   output logic [1:0] beat,
   output logic [1:0] alo,
   output logic       start,
   output logic       take,
   output logic       done_q,
   output logic       err_q
);
   logic last;

   assign last  = ({1'b0, beat} == nbeats - 3'd1);
   assign start = (st == ST_IDLE) && req_valid && !done_q && !err_q;
   assign take  = (st == ST_DATA) && !ta_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         beat   <= '0;
         alo    <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               st   <= ST_START;
               beat <= '0;
               alo  <= alo_init;
            end
            ST_START: st <= ST_DATA;
            ST_DATA: begin
               if (!ta_n) begin
                  if (last) begin
                     if (rhold && !req_write) st <= ST_HOLD;
                     else begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                     end
                  end else begin
                     beat <= beat + 2'd1;
                     alo  <= alo + step;
                     st   <= aset ? ST_GAP : ST_DATA;
                  end
               end else if (expired) begin
                  st    <= ST_IDLE;
                  err_q <= 1'b1;
               end
            end
            ST_GAP: st <= ST_DATA;
            ST_HOLD: begin
               st     <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/szbus_rdasm.sv
module szbus_rdasm #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          take,
   input  logic [5:0]    pw,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] acc
);
   localparam logic [5:0] FULL = 6'(DW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (clear) acc <= '0;
      else if (take)  acc <= (acc << pw) | (din >> (FULL - pw));
   end
endmodule

// File: rtl/szbus_wrlane.sv
module szbus_wrlane
   import szbus_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] wdata,
   input  logic [1:0]    size,
   input  logic [1:0]    port,
   input  logic [1:0]    addr_lo,
   input  logic [1:0]    beat,
   input  logic          drive,
   input  logic          we_en,
   output logic [DW-1:0] dout,
   output logic [3:0]    we_n
);
   localparam int LANES = DW / 8;

   logic [DW-1:0] op;
   logic [7:0]    sh;
   logic [3:0]    mask;

   always_comb begin
      case (size)
         2'd0:    op = {LANES{wdata[7:0]}};
         2'd1:    op = {(LANES/2){wdata[15:0]}};
         default: op = wdata;
      endcase
   end

   assign sh   = 8'(beat) * 8'(port_bits(port));
   assign dout = drive ? (op << sh) : '0;
   assign mask = lane_mask(port, size, addr_lo);

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign we_n[g] = !(we_en && mask[g]);
   end
endmodule

// File: rtl/szport_bus_ctl.sv
module szport_bus_ctl
   import szbus_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MON_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_port,
   input  logic              cfg_aset,
   input  logic              cfg_rhold,
   input  logic [MON_W-1:0]  cfg_timeout,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic              req_super,
   input  logic [31:0]       req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              bus_ts_n,
   output logic              bus_cs_n,
   output logic              bus_super,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [3:0]        bus_we_n,
   output logic [31:0]       bus_dout,
   input  logic [31:0]       bus_din,
   input  logic              bus_ta_n
);
   localparam int DW = 32;

   initial begin
      assert (ADDR_W >= 3) else $error("ADDR_W must be at least 3");
      assert (MON_W >= 2)  else $error("MON_W must be at least 2");
   end

   state_t     st;
   logic [1:0] beat, alo;
   logic       start, take, done_q, err_q, expired, first, in_data;

   assign in_data = (st == ST_DATA);

   szbus_mon #(.MON_W(MON_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .ta_n(bus_ta_n),
      .limit(cfg_timeout), .expired(expired), .first(first)
   );

   szbus_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .ta_n(bus_ta_n), .aset(cfg_aset), .rhold(cfg_rhold),
      .nbeats(beat_count(cfg_port, req_size)), .step(port_step(cfg_port)),
      .alo_init(req_addr[1:0]), .expired(expired),
      .st(st), .beat(beat), .alo(alo), .start(start), .take(take),
      .done_q(done_q), .err_q(err_q)
   );

   szbus_rdasm #(.DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n), .clear(start), .take(take && !req_write),
      .pw(port_bits(cfg_port)), .din(bus_din), .acc(rsp_rdata)
   );

   szbus_wrlane #(.DW(DW)) u_wr (
      .wdata(req_wdata), .size(req_size), .port(cfg_port), .addr_lo(req_addr[1:0]),
      .beat(beat), .drive(req_write && (st != ST_IDLE)),
      .we_en(in_data && req_write && (!cfg_aset || !first)),
      .dout(bus_dout), .we_n(bus_we_n)
   );

   assign rsp_done  = done_q;
   assign rsp_err   = err_q;
   assign bus_ts_n  = (st != ST_START);
   assign bus_cs_n  = !in_data;
   assign bus_super = (st != ST_IDLE) && req_super;
   assign bus_addr  = {req_addr[ADDR_W-1:2], alo};
endmodule

// File: rtl/szbus_chk.sv
module szbus_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_aset,
   input logic              bus_ts_n,
   input logic              bus_cs_n,
   input logic [3:0]        bus_we_n,
   input logic              bus_ta_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rsp_done,
   input logic              rsp_err
);
   assert_ts_lone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ts_n |=> bus_ts_n);
   assert_cs_follows_ts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ts_n |=> !bus_cs_n);
   assert_ts_cs_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ts_n |-> bus_cs_n);
   assert_addr_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && bus_ta_n) |=> $stable(bus_addr));
   assert_we_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(&bus_we_n) |-> !bus_cs_n);
   assert_setup_no_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_aset && $fell(bus_cs_n)) |-> (&bus_we_n));
   assert_resp_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done || rsp_err) |-> (bus_cs_n && bus_ts_n));
   assert_resp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_done && rsp_err));
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
endmodule

bind szport_bus_ctl szbus_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_aset(cfg_aset), .bus_ts_n(bus_ts_n),
   .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_ta_n(bus_ta_n),
   .bus_addr(bus_addr), .rsp_done(rsp_done), .rsp_err(rsp_err)
);

// File: tb/tb_szport_bus_ctl.sv
module tb_szport_bus_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_port = 2'd0;
   logic        cfg_aset = 1'b0, cfg_rhold = 1'b0;
   logic [7:0]  cfg_timeout = 8'd15;
   logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
   logic [31:0] req_addr = 32'h4000_0000, req_wdata = '0, bus_din = '0;
   logic [1:0]  req_size = 2'd0;
   logic        bus_ta_n = 1'b1;
   logic        rsp_done, rsp_err, bus_ts_n, bus_cs_n, bus_super;
   logic [31:0] rsp_rdata, bus_addr, bus_dout;
   logic [3:0]  bus_we_n;

   int checks = 0, failures = 0;

   always #4 clk = ~clk;

   szport_bus_ctl dut (.*);

   typedef struct packed {
      logic [1:0]  port;  logic [1:0] size; logic wr; logic aset; logic rhold;
      logic [1:0]  alo;   logic [3:0] wt;   logic [31:0] data;
      logic [2:0]  beats; logic [31:0] res; logic [3:0] we; logic [1:0] alast; logic [1:0] gaps;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 4'd0, 32'h1234_5678, 3'd2, 32'h1234_5678, 4'h0, 2'd2, 2'd1},
      '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1, 32'hA1B2_C3D4, 3'd4, 32'hA1B2_C3D4, 4'h0, 2'd3, 2'd0},
      '{2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, 4'd0, 32'h0000_BEEF, 3'd2, 32'h0000_BEEF, 4'h8, 2'd3, 2'd0},
      '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 4'd0, 32'h0000_005A, 3'd1, 32'h5A5A_5A5A, 4'h4, 2'd1, 2'd0},
      '{2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 4'd0, 32'hCAFE_F00D, 3'd2, 32'hCAFE_F00D, 4'h0, 2'd2, 2'd1},
      '{2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 4'd2, 32'h0102_0304, 3'd2, 32'h0102_0304, 4'hC, 2'd2, 2'd1},
      '{2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 4'd3, 32'h5566_7788, 3'd1, 32'h5566_7788, 4'h0, 2'd2, 2'd0},
      '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 4'd1, 32'h0000_0077, 3'd1, 32'h0000_7777, 4'h4, 2'd1, 2'd0},
      '{2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 32'hDEAD_BEEF, 3'd1, 32'hDEAD_BEEF, 4'hF, 2'd0, 2'd0},
      '{2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, 4'd0, 32'h0000_1234, 3'd1, 32'h1234_1234, 4'h3, 2'd2, 2'd0},
      '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 4'd0, 32'h9A00_0000, 3'd1, 32'h0000_009A, 4'h0, 2'd3, 2'd0},
      '{2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd1, 32'hBEAD_0000, 3'd1, 32'h0000_BEAD, 4'h0, 2'd0, 2'd0},
      '{2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 4'd1, 32'h1122_3344, 3'd4, 32'h1122_3344, 4'h8, 2'd3, 2'd3}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int pw, acks, k, ts_cnt, gaps;
      logic [31:0] obs;
      logic [3:0]  we_seen;
      logic [1:0]  last_alo;
      bit          fin, bad_err;
      pw = (v.port == 2'd1) ? 16 : (v.port == 2'd2) ? 8 : 32;
      acks = 0; k = 0; ts_cnt = 0; gaps = 0; obs = '0; we_seen = '0; last_alo = '0;
      fin = 0; bad_err = 0;
      @(negedge clk);
      cfg_port = v.port; cfg_aset = v.aset; cfg_rhold = v.rhold; cfg_timeout = 8'd15;
      req_size = v.size; req_write = v.wr; req_super = 1'b0;
      req_addr = 32'h4000_0000 | 32'(v.alo); req_wdata = v.data; req_valid = 1'b1;
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         if (rsp_done || rsp_err) begin fin = rsp_done; bad_err = rsp_err; break; end
         if (!bus_ts_n) ts_cnt++;
         if (!bus_cs_n) begin
            we_seen |= ~bus_we_n;
            if (k >= int'(v.wt)) begin
               bus_ta_n = 1'b0;
               bus_din  = v.data << (acks * pw);
               if (v.wr) obs = (obs << pw) | (bus_dout >> (32 - pw));
               last_alo = bus_addr[1:0];
               acks++; k = 0;
            end else begin
               bus_ta_n = 1'b1; k++;
            end
         end else begin
            bus_ta_n = 1'b1;
            if (acks > 0 && acks < int'(v.beats)) gaps++;
         end
      end
      req_valid = 1'b0; bus_ta_n = 1'b1;
      chk(fin && !bad_err, $sformatf("R11 vec%0d done", idx), 32'(fin), 32'd1);
      chk(ts_cnt == 1, $sformatf("R2 vec%0d start strobes", idx), 32'(ts_cnt), 32'd1);
      chk(acks == int'(v.beats), $sformatf("R3 vec%0d beats", idx), 32'(acks), 32'(v.beats));
      chk(last_alo == v.alast, $sformatf("R3 vec%0d last A[1:0]", idx), 32'(last_alo), 32'(v.alast));
      if (v.wr) chk(obs == v.res, $sformatf("R6 vec%0d write lanes", idx), obs, v.res);
      else      chk(rsp_rdata == v.res, $sformatf("R5 vec%0d read data", idx), rsp_rdata, v.res);
      chk(we_seen == v.we, $sformatf("%s vec%0d write enables", (v.aset && v.wr) ? "R8" : "R6", idx),
          32'(we_seen), 32'(v.we));
      chk(gaps == int'(v.gaps), $sformatf("R7 vec%0d gap clocks", idx), 32'(gaps), 32'(v.gaps));
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      int n;
      bit got;
      logic [31:0] a0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(bus_cs_n && bus_ts_n, "R1 reset strobes", {bus_cs_n, bus_ts_n}, 32'd3);
      chk(bus_we_n == 4'hF, "R1 reset write enables", 32'(bus_we_n), 32'hF);
      chk(!rsp_done && !rsp_err, "R1 reset responses", {rsp_done, rsp_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n && bus_ts_n && !rsp_done, "R1 idle after reset", {bus_cs_n, bus_ts_n}, 32'd3);

      for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

      // R2 start sequence and supervisor flag, R11 no restart during done
      @(negedge clk);
      cfg_port = 2'd0; cfg_aset = 1'b0; cfg_rhold = 1'b0; cfg_timeout = 8'd15;
      req_size = 2'd2; req_write = 1'b0; req_super = 1'b1; req_addr = 32'h4000_0000;
      req_valid = 1'b1;
      @(negedge clk);
      chk(!bus_ts_n && bus_cs_n, "R2 start clock", {bus_ts_n, bus_cs_n}, 32'd1);
      chk(bus_super, "R2 supervisor at start", 32'(bus_super), 32'd1);
      @(negedge clk);
      chk(bus_ts_n && !bus_cs_n, "R2 data clock", {bus_ts_n, bus_cs_n}, 32'd2);
      chk(bus_super, "R2 supervisor in data", 32'(bus_super), 32'd1);
      bus_ta_n = 1'b0; bus_din = 32'h0BAD_F00D;
      @(negedge clk);
      bus_ta_n = 1'b1;
      chk(rsp_done && bus_cs_n, "R11 done after ack", 32'(rsp_done), 32'd1);
      chk(rsp_rdata == 32'h0BAD_F00D, "R5 full-width read", rsp_rdata, 32'h0BAD_F00D);
      @(negedge clk);
      chk(!rsp_done && bus_ts_n && bus_cs_n, "R11 no restart while done shown",
          {rsp_done, bus_ts_n, bus_cs_n}, 32'd3);
      req_valid = 1'b0; req_super = 1'b0;

      // R9 read hold
      @(negedge clk);
      cfg_port = 2'd1; cfg_rhold = 1'b1; req_size = 2'd1; req_addr = 32'h4000_0000;
      req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      a0 = bus_addr;
      bus_ta_n = 1'b0; bus_din = 32'hC0DE_0000;
      @(negedge clk);
      bus_ta_n = 1'b1;
      chk(bus_cs_n && !rsp_done, "R9 hold clock chip select high", {bus_cs_n, rsp_done}, 32'd2);
      chk(bus_addr == a0, "R9 hold clock address", bus_addr, a0);
      @(negedge clk);
      chk(rsp_done, "R9 done after hold", 32'(rsp_done), 32'd1);
      req_valid = 1'b0; cfg_rhold = 1'b0;

      // R10 timeout
      @(negedge clk);
      cfg_port = 2'd0; cfg_timeout = 8'd4; req_size = 2'd2; req_valid = 1'b1;
      n = 0; got = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (rsp_err) begin got = 1; break; end
         if (!bus_cs_n) n++;
      end
      chk(got && !rsp_done && bus_cs_n, "R10 error pulse", {got, rsp_done, bus_cs_n}, 32'h5);
      chk(n == 4, "R10 data clocks before error", 32'(n), 32'd4);
      req_valid = 1'b0;
      @(negedge clk);
      chk(!rsp_err, "R10 error single clock", 32'(rsp_err), 32'd0);

      // R10 zero disables monitor, R4 wait states hold address
      cfg_timeout = 8'd0; req_addr = 32'h4000_0003; req_size = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      a0 = bus_addr; n = 0; got = 0;
      for (int c = 0; c < 30; c++) begin
         if (rsp_err) got = 1;
         if (bus_cs_n || bus_addr != a0) n++;
         @(negedge clk);
      end
      chk(!got, "R10 zero timeout never errors", 32'(got), 32'd0);
      chk(n == 0, "R4 wait states hold address and select", 32'(n), 32'd0);
      bus_ta_n = 1'b0; bus_din = 32'h7700_0000;
      @(negedge clk);
      bus_ta_n = 1'b1;
      chk(rsp_done && !rsp_err, "R4 late acknowledge completes", 32'(rsp_done), 32'd1);
      req_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule